// File: doc/BRIEF.md
# Temperature Limit Event Generator

The block compares each new temperature sample against three programmable two's-complement limits: a high limit, a low limit and a critical limit. It drives a single event pin from the result. Samples arrive as a signed word qualified by a one-cycle valid strobe. The most recent sample is held on an output, so it can be read at any time, together with three status bits. Each status bit records which limit the latest sample crossed.

Two configuration inputs shape the event pin.

- **Polarity.** One input selects whether the pin is active high or active low.
- **Mode.** The other input selects comparator or interrupt mode.
  - In comparator mode the pin follows the latest sample: it is active while the sample is out of range and inactive once a sample is back in range.
  - In interrupt mode an out-of-range sample sets a sticky event that stays active until a clear strobe arrives.
- **Critical override.** A sample above the critical limit forces the event active in either mode. While the latest sample stays above the critical limit, the clear strobe is refused.

The event logic is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No event |
| `ST_CMP_ACT` | Comparator-mode event |
| `ST_INT_LATCH` | Sticky interrupt event |
| `ST_CRIT` | Critical event |

Transitions:

- **Clear step.** A clear strobe first moves `ST_INT_LATCH` to `ST_IDLE`.
- **Sample step.** A valid sample is then evaluated from the resulting state:
  - above critical, it goes to `ST_CRIT`;
  - out of range but not critical, it goes to `ST_INT_LATCH` in interrupt mode or `ST_CMP_ACT` in comparator mode;
  - in range, it goes to `ST_IDLE`, except that `ST_INT_LATCH` and `ST_CRIT` go to `ST_INT_LATCH` in interrupt mode.
- **No strobe.** With neither strobe present, the state holds.

Top module: `tle_event_gen`

## Requirements
- R1: After reset the held temperature is 0, all three status bits are 0, and the event is inactive. The pin is therefore 0 when active-high is selected and 1 when active-low is selected.
- R2: On each valid strobe the held temperature takes the strobed sample, visible one clock later. Between strobes it keeps its value.
- R3: On each valid strobe the status bits are set as follows, visible one clock later. above-high is set when the sample is greater than the high limit. below-low is set when the sample is less than the low limit. above-critical is set when the sample is greater than the critical limit. A sample equal to a limit sets no bit.
- R4: In comparator mode (cfg_intr_mode=0) the event is active one clock after an out-of-range sample (above high or below low). It is inactive one clock after an in-range, non-critical sample.
- R5: In interrupt mode (cfg_intr_mode=1) the event stays active after an out-of-range sample, through later in-range samples, until a clear strobe.
- R6: In interrupt mode a clear strobe with no sample makes the event inactive one clock later. A clear strobe coinciding with an out-of-range sample leaves the event active.
- R7: A sample above the critical limit makes the event active one clock later in either mode. A clear strobe is ignored while the latest sample is above critical. Once a non-critical sample arrives, comparator mode follows the range again, while interrupt mode keeps the event until a clear.
- R8: The pin equals the event state when cfg_active_high=1 and its inverse when cfg_active_high=0. A polarity change reaches the pin in the same cycle.
- R9: Samples and limits are two's complement and all comparisons are signed, so negative samples and negative limits compare correctly.
- R10: Without a valid strobe, changing a limit changes neither the status bits nor the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe qualifying smp_temp |
| smp_temp | input | TEMP_W | Signed temperature sample |
| lim_high | input | TEMP_W | Signed high limit |
| lim_low | input | TEMP_W | Signed low limit |
| lim_crit | input | TEMP_W | Signed critical limit |
| cfg_active_high | input | 1 | 1: pin active high, 0: pin active low |
| cfg_intr_mode | input | 1 | 1: interrupt mode, 0: comparator mode |
| evt_clr | input | 1 | One-cycle strobe clearing a latched interrupt |
| evt_pin | output | 1 | Event pin level after polarity |
| temp_held | output | TEMP_W | Most recent sample |
| stat_above_high | output | 1 | Latest sample was above the high limit |
| stat_below_low | output | 1 | Latest sample was below the low limit |
| stat_above_crit | output | 1 | Latest sample was above the critical limit |

## Verification
The outputs do not all settle at the same moment:

- **Registered results.** The held temperature, the status bits and the event state are each one register deep. Their new values are due one clock after the edge that samples the valid or clear strobe.
- **Polarity.** The pin's polarity is combinational, so a change of cfg_active_high is due in the same cycle.

The bench drives every input on a falling edge and holds it for one full clock. It then checks on the next falling edge, which is exactly one rising edge after the stimulus. For polarity it checks a short delay after changing the input, with no clock edge in between. Hold and ignored-clear checks wait several clocks with no strobe before reading the outputs.

// File: rtl/tle_pkg.sv
package tle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CMP_ACT   = 2'd1,
        ST_INT_LATCH = 2'd2,
        ST_CRIT      = 2'd3
    } tle_state_e;

    localparam int LIM_HIGH = 0;
    localparam int LIM_LOW  = 1;
    localparam int LIM_CRIT = 2;
    localparam int NUM_LIM  = 3;

    // bit order follows the limit indices above
    typedef struct packed {
        logic crit;
        logic low;
        logic high;
    } tle_flags_t;

endpackage

// File: rtl/tle_limit_cmp.sv
module tle_limit_cmp
    import tle_pkg::*;
#(
    parameter int TEMP_W = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [TEMP_W-1:0] smp_temp,
    input  logic signed [TEMP_W-1:0] lim_vec [NUM_LIM],
    output tle_flags_t               hit_now,
    output tle_flags_t               flags_q,
    output logic signed [TEMP_W-1:0] temp_q
);

    logic [NUM_LIM-1:0] hit_vec;

    // one signed comparator per limit; the low limit checks the other direction
    for (genvar gi = 0; gi < NUM_LIM; gi++) begin : g_lim
        if (gi == LIM_LOW) begin : g_below
            assign hit_vec[gi] = (smp_temp < lim_vec[gi]);
        end else begin : g_above
            assign hit_vec[gi] = (smp_temp > lim_vec[gi]);
        end
    end

    assign hit_now = tle_flags_t'(hit_vec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            temp_q  <= '0;
        end else if (smp_valid) begin
            flags_q <= hit_now;
            temp_q  <= smp_temp;
        end
    end

    a_r2_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> temp_q == $past(smp_temp));

    a_r10_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(flags_q) && $stable(temp_q)));

endmodule

// File: rtl/tle_event_fsm.sv
module tle_event_fsm
    import tle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  tle_flags_t hit,
    input  logic       intr_mode,
    input  logic       clr,
    output logic       evt_active
);

    tle_state_e state, base, nxt;

    always_comb begin
        base = state;
        if (clr && state == ST_INT_LATCH) begin
            base = ST_IDLE;
        end
        nxt = base;
        if (smp_valid) begin
            if (hit.crit) begin
                nxt = ST_CRIT;
            end else if (hit.high || hit.low) begin
                nxt = intr_mode ? ST_INT_LATCH : ST_CMP_ACT;
            end else begin
                unique case (base)
                    ST_IDLE:      nxt = ST_IDLE;
                    ST_CMP_ACT:   nxt = ST_IDLE;
                    ST_INT_LATCH: nxt = intr_mode ? ST_INT_LATCH : ST_IDLE;
                    ST_CRIT:      nxt = intr_mode ? ST_INT_LATCH : ST_IDLE;
                    default:      nxt = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        evt_active = (state != ST_IDLE);
    end

    a_r7_crit_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRIT && !smp_valid) |=> state == ST_CRIT);

    a_r5_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_LATCH && !clr && intr_mode) |=> state != ST_IDLE);

    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_LATCH && clr && !smp_valid) |=> state == ST_IDLE);

    a_r4_cmp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !intr_mode && !hit.high && !hit.low && !hit.crit) |=> state == ST_IDLE);

    a_r10_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !clr) |=> $stable(state));

endmodule

// File: rtl/tle_event_gen.sv
module tle_event_gen
    import tle_pkg::*;
#(
    parameter int TEMP_W = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [TEMP_W-1:0] smp_temp,
    input  logic signed [TEMP_W-1:0] lim_high,
    input  logic signed [TEMP_W-1:0] lim_low,
    input  logic signed [TEMP_W-1:0] lim_crit,
    input  logic                     cfg_active_high,
    input  logic                     cfg_intr_mode,
    input  logic                     evt_clr,
    output logic                     evt_pin,
    output logic signed [TEMP_W-1:0] temp_held,
    output logic                     stat_above_high,
    output logic                     stat_below_low,
    output logic                     stat_above_crit
);

    logic signed [TEMP_W-1:0] lim_vec [NUM_LIM];
    tle_flags_t               hit_now;
    tle_flags_t               flags_q;
    logic                     evt_active;

    assign lim_vec[LIM_HIGH] = lim_high;
    assign lim_vec[LIM_LOW]  = lim_low;
    assign lim_vec[LIM_CRIT] = lim_crit;

    tle_limit_cmp #(.TEMP_W(TEMP_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_temp  (smp_temp),
        .lim_vec   (lim_vec),
        .hit_now   (hit_now),
        .flags_q   (flags_q),
        .temp_q    (temp_held)
    );

    tle_event_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .hit        (hit_now),
        .intr_mode  (cfg_intr_mode),
        .clr        (evt_clr),
        .evt_active (evt_active)
    );

    assign evt_pin         = cfg_active_high ? evt_active : ~evt_active;
    assign stat_above_high = flags_q.high;
    assign stat_below_low  = flags_q.low;
    assign stat_above_crit = flags_q.crit;

    a_r7_crit_pin_active: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_temp > lim_crit) |=> evt_active);

    a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !evt_clr && $stable(cfg_active_high)) |=> $stable(evt_pin));

endmodule

// File: tb/tle_event_gen_test.sv
module tle_event_gen_test;

    localparam int TW = 13;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [TW-1:0] smp_temp = '0;
    logic signed [TW-1:0] lim_high = 13'sd100;
    logic signed [TW-1:0] lim_low = 13'sd10;
    logic signed [TW-1:0] lim_crit = 13'sd200;
    logic                 cfg_active_high = 1'b1;
    logic                 cfg_intr_mode = 1'b0;
    logic                 evt_clr = 1'b0;
    logic                 evt_pin;
    logic signed [TW-1:0] temp_held;
    logic                 stat_above_high, stat_below_low, stat_above_crit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tle_event_gen #(.TEMP_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .lim_high(lim_high), .lim_low(lim_low), .lim_crit(lim_crit),
        .cfg_active_high(cfg_active_high), .cfg_intr_mode(cfg_intr_mode),
        .evt_clr(evt_clr), .evt_pin(evt_pin), .temp_held(temp_held),
        .stat_above_high(stat_above_high), .stat_below_low(stat_below_low),
        .stat_above_crit(stat_above_crit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int t);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_temp  = TW'(t);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pin", evt_pin, 0);
        chk("R1 high", stat_above_high, 0);
        chk("R1 low", stat_below_low, 0);
        chk("R1 crit", stat_above_crit, 0);
        chk("R1 temp", int'(temp_held), 0);
        cfg_active_high = 1'b0; #1;
        chk("R1 pin active-low", evt_pin, 1);
        cfg_active_high = 1'b1; #1;
    endtask

    task automatic t_comparator();
        cfg_intr_mode = 1'b0;
        send(50);
        chk("R4 in range pin", evt_pin, 0);
        chk("R2 temp", int'(temp_held), 50);
        send(150);
        chk("R4 above pin", evt_pin, 1);
        chk("R3 above-high", stat_above_high, 1);
        send(100);
        chk("R3 equal high no flag", stat_above_high, 0);
        chk("R4 back in range pin", evt_pin, 0);
        send(5);
        chk("R3 below-low", stat_below_low, 1);
        chk("R4 below pin", evt_pin, 1);
        send(10);
        chk("R3 equal low no flag", stat_below_low, 0);
        chk("R4 pin off", evt_pin, 0);
    endtask

    task automatic t_signed();
        send(-5);
        chk("R9 negative below low", stat_below_low, 1);
        chk("R9 pin", evt_pin, 1);
        chk("R2 temp negative", int'(temp_held), -5);
        lim_low = -13'sd20;
        send(-5);
        chk("R9 above negative low", stat_below_low, 0);
        chk("R9 pin off", evt_pin, 0);
        send(-100);
        chk("R9 below negative low", stat_below_low, 1);
        lim_low = 13'sd10;
        send(50);
    endtask

    task automatic t_hold();
        lim_high = 13'sd20;
        lim_crit = 13'sd30;
        repeat (5) @(negedge clk);
        chk("R10 high unchanged", stat_above_high, 0);
        chk("R10 crit unchanged", stat_above_crit, 0);
        chk("R10 pin unchanged", evt_pin, 0);
        chk("R2 temp held", int'(temp_held), 50);
        lim_high = 13'sd100;
        lim_crit = 13'sd200;
    endtask

    task automatic t_interrupt();
        cfg_intr_mode = 1'b1;
        send(150);
        chk("R5 set", evt_pin, 1);
        send(50);
        chk("R5 sticky pin", evt_pin, 1);
        chk("R3 high cleared by sample", stat_above_high, 0);
        clear();
        chk("R6 cleared", evt_pin, 0);
        send(5);
        chk("R5 set by low", evt_pin, 1);
        @(negedge clk);
        smp_valid = 1'b1; smp_temp = 13'sd150; evt_clr = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; evt_clr = 1'b0;
        chk("R6 clear with out-of-range sample", evt_pin, 1);
        clear();
        chk("R6 cleared again", evt_pin, 0);
    endtask

    task automatic t_critical();
        cfg_intr_mode = 1'b0;
        send(250);
        chk("R7 cmp crit pin", evt_pin, 1);
        chk("R7 crit flag", stat_above_crit, 1);
        chk("R3 high with crit", stat_above_high, 1);
        clear();
        repeat (2) @(negedge clk);
        chk("R7 clear ignored", evt_pin, 1);
        send(150);
        chk("R7 cmp high after crit", evt_pin, 1);
        chk("R7 crit flag drops", stat_above_crit, 0);
        send(50);
        chk("R7 cmp in range after crit", evt_pin, 0);
        cfg_intr_mode = 1'b1;
        send(250);
        chk("R7 intr crit pin", evt_pin, 1);
        clear();
        chk("R7 intr clear ignored", evt_pin, 1);
        send(50);
        chk("R7 intr stays latched", evt_pin, 1);
        clear();
        chk("R7 intr cleared", evt_pin, 0);
    endtask

    task automatic t_polarity();
        cfg_intr_mode = 1'b0;
        send(50);
        cfg_active_high = 1'b0; #1;
        chk("R8 inactive low-polarity", evt_pin, 1);
        send(150);
        chk("R8 active low-polarity", evt_pin, 0);
        cfg_active_high = 1'b1; #1;
        chk("R8 switch same cycle", evt_pin, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_comparator();
        t_signed();
        t_hold();
        t_interrupt();
        t_critical();
        t_polarity();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule